// File: doc/BRIEF.md
# Prioritized Interrupt Controller with Core Handshake

This block sits between a set of interrupt sources and a processor core. Each request line has a two-bit priority. The block finds the strongest pending request and compares it with the mask level that the core reports on a two-bit status input. When the request may interrupt, the block raises an interrupt line and drives a level code. The core latches that code and returns it on the status input, so a running handler can only be interrupted by a higher priority.

After the interrupt line rises, the core lowers its enable. On that cycle the block latches the winning source. From the next cycle it drives that source's vector address on the vector address bus, and holds it there until the core acknowledges. The acknowledge drops the interrupt line. No new interrupt is raised until the core raises its enable again.

Eight core exceptions have fixed priorities and need no enable. A parameterised number of programmable sources each have an enable bit and a priority field, supplied on input ports. While reset is active the bus carries a reset vector, and the block holds it for two clock edges after reset is released.

Top module: `irq_prio_ctrl`

## Requirements
- R1: While `rst_n` is low, and up to the second rising clock edge after it rises, `vab` equals `RESET_VEC` (default 16'h0080). After that, and whenever no vector is being served, `vab` is 0.
- R2: The core exception inputs `core_req[7:0]` need no enable and have fixed priorities. Bits 0 to 3 (illegal instruction, stack overflow, misaligned long access, software level 3) are priority 3. Bit 4 (software level 2) is priority 2, bit 5 (software level 1) is priority 1, and bit 6 (software level 0) is priority 0. Bit 7 is the low-priority software interrupt, which ranks below priority 0.
- R3: A programmable source `i` is global index `8+i`. It takes part in arbitration only when `prog_en[i]` is 1. Its priority is `prog_prio[2i+1:2i]`.
- R4: The `sr_lvl` input masks requests. Value 0 permits priorities 0 to 3, value 1 permits 1 to 3, value 2 permits 2 to 3, and value 3 permits only priority 3.
- R5: On the edge that raises `irq`, `ipl` takes the level code of the accepted request: 01 for priority 0, 10 for priority 1, 11 for priority 2 or 3, and 00 for the low-priority software interrupt. The code holds until the next accepted interrupt.
- R6: `irq` rises only from idle, while `pic_en` is 1 and a permitted request is pending. After `pic_en` is sampled low, `vab` equals `VEC_BASE + index*VEC_STRIDE` (default 16'h0100 + 2*index) from the next cycle.
- R7: When `iack` is sampled high while a vector is served, `irq` is low from the next cycle. It stays low until `pic_en` has been sampled high again, even with requests pending.
- R8: The served source is the best request pending on the cycle `pic_en` is sampled low. `vab` stays stable until `iack`, whatever the requests do in the meantime.
- R9: Among pending requests at the same priority, the one with the lowest global index wins. A higher priority always beats a lower one.
- R10: The low-priority software interrupt is accepted only when `sr_lvl` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| core_req | input | 8 | Fixed core exception requests |
| prog_req | input | NUM_PROG | Programmable source requests |
| prog_en | input | NUM_PROG | Per-source enable |
| prog_prio | input | 2*NUM_PROG | Per-source two-bit priority |
| sr_lvl | input | 2 | Current mask level from the core |
| pic_en | input | 1 | Core enable; low means "drive the vector" |
| iack | input | 1 | Core acknowledge |
| irq | output | 1 | Interrupt request to the core |
| ipl | output | 2 | Level code for the accepted request |
| vab | output | ADDR_W | Vector address bus |

## Verification
A wrong arbitration or mask decision shows within one cycle of a request: `irq` either rises when it must not or stays low. It also shows one cycle after `pic_en` falls as a wrong address on `vab`. A corrupted handshake state shows as `irq` rising with `pic_en` low, or as `irq` still high the cycle after `iack`. A wrong latch shows as `vab` moving while a vector is served. A reset counter fault shows on the first or second edge after reset is released, when `vab` leaves the reset vector too early or too late.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int NUM_CORE = 8;
    localparam int RANK_W   = 3;

    // rank 0: nothing pending, 1: low-priority software, 2..5: priority 0..3
    localparam logic [RANK_W-1:0] RK_NONE = 3'd0;
    localparam logic [RANK_W-1:0] RK_LOW  = 3'd1;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ASSERT,
        ST_SERVE,
        ST_WAIT
    } hs_state_e;

    function automatic logic [RANK_W-1:0] core_rank(input int idx);
        if (idx <= 3)      return 3'd5;
        else if (idx == 4) return 3'd4;
        else if (idx == 5) return 3'd3;
        else if (idx == 6) return 3'd2;
        else               return RK_LOW;
    endfunction

    function automatic logic rank_permitted(input logic [RANK_W-1:0] rank,
                                            input logic [1:0] sr);
        if (rank == RK_NONE)     return 1'b0;
        else if (rank == RK_LOW) return (sr == 2'd0);
        else                     return ({1'b0, sr} <= (rank - 3'd2));
    endfunction

    function automatic logic [1:0] rank_level(input logic [RANK_W-1:0] rank);
        if (rank <= RK_LOW)     return 2'd0;
        else if (rank >= 3'd4)  return 2'd3;
        else                    return rank[1:0] - 2'd1;
    endfunction

endpackage

// File: rtl/irqc_rank_map.sv
module irqc_rank_map
    import irqc_pkg::*;
#(
    parameter int NUM_PROG = 8,
    localparam int NUM_SRC = NUM_CORE + NUM_PROG
) (
    input  logic [NUM_CORE-1:0]            core_req,
    input  logic [NUM_PROG-1:0]            prog_req,
    input  logic [NUM_PROG-1:0]            prog_en,
    input  logic [2*NUM_PROG-1:0]          prog_prio,
    output logic [NUM_SRC-1:0][RANK_W-1:0] rank
);

    for (genvar g = 0; g < NUM_CORE; g++) begin : g_core
        assign rank[g] = core_req[g] ? core_rank(g) : RK_NONE;
    end

    for (genvar g = 0; g < NUM_PROG; g++) begin : g_prog
        assign rank[NUM_CORE+g] = (prog_req[g] && prog_en[g])
                                ? ({1'b0, prog_prio[2*g +: 2]} + 3'd2)
                                : RK_NONE;
    end

endmodule

// File: rtl/irqc_pick.sv
module irqc_pick
    import irqc_pkg::*;
#(
    parameter int NUM_SRC = 16,
    localparam int IDX_W  = $clog2(NUM_SRC)
) (
    input  logic [NUM_SRC-1:0][RANK_W-1:0] rank,
    output logic                           found,
    output logic [IDX_W-1:0]               best_idx,
    output logic [RANK_W-1:0]              best_rank
);

    // scan downward with >= so that the lowest index wins a tie
    always_comb begin
        best_rank = RK_NONE;
        best_idx  = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (rank[i] != RK_NONE && rank[i] >= best_rank) begin
                best_rank = rank[i];
                best_idx  = IDX_W'(i);
            end
        end
    end

    assign found = (best_rank != RK_NONE);

endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
    import irqc_pkg::*;
#(
    parameter int          NUM_PROG   = 8,
    parameter int          ADDR_W     = 16,
    parameter logic [15:0] VEC_BASE   = 16'h0100,
    parameter logic [15:0] VEC_STRIDE = 16'h0002,
    parameter logic [15:0] RESET_VEC  = 16'h0080
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [7:0]            core_req,
    input  logic [NUM_PROG-1:0]   prog_req,
    input  logic [NUM_PROG-1:0]   prog_en,
    input  logic [2*NUM_PROG-1:0] prog_prio,
    input  logic [1:0]            sr_lvl,
    input  logic                  pic_en,
    input  logic                  iack,
    output logic                  irq,
    output logic [1:0]            ipl,
    output logic [ADDR_W-1:0]     vab
);

    localparam int NUM_SRC = NUM_CORE + NUM_PROG;
    localparam int IDX_W   = $clog2(NUM_SRC);

    typedef struct packed {
        hs_state_e      state;
        logic           irq;
        logic [1:0]     lvl;
        logic [IDX_W-1:0] idx;
        logic [1:0]     rst_cnt;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;

    logic [NUM_SRC-1:0][RANK_W-1:0] rank;
    logic                           found;
    logic [IDX_W-1:0]               best_idx;
    logic [RANK_W-1:0]              best_rank;
    logic                           rst_done;

    irqc_rank_map #(.NUM_PROG(NUM_PROG)) u_map (
        .core_req (core_req),
        .prog_req (prog_req),
        .prog_en  (prog_en),
        .prog_prio(prog_prio),
        .rank     (rank)
    );

    irqc_pick #(.NUM_SRC(NUM_SRC)) u_pick (
        .rank     (rank),
        .found    (found),
        .best_idx (best_idx),
        .best_rank(best_rank)
    );

    assign rst_done = (ctrl_q.rst_cnt == 2'd2);

    always_comb begin
        ctrl_d = ctrl_q;
        if (!rst_done) begin
            ctrl_d.rst_cnt = ctrl_q.rst_cnt + 2'd1;
        end
        unique case (ctrl_q.state)
            ST_IDLE: begin
                if (rst_done && pic_en && rank_permitted(best_rank, sr_lvl)) begin
                    ctrl_d.state = ST_ASSERT;
                    ctrl_d.irq   = 1'b1;
                    ctrl_d.lvl   = rank_level(best_rank);
                    ctrl_d.idx   = best_idx;
                end
            end
            ST_ASSERT: begin
                if (!pic_en) begin
                    ctrl_d.state = ST_SERVE;
                    if (found) begin
                        ctrl_d.idx = best_idx;
                    end
                end
            end
            ST_SERVE: begin
                if (iack) begin
                    ctrl_d.state = ST_WAIT;
                    ctrl_d.irq   = 1'b0;
                end
            end
            ST_WAIT: begin
                if (pic_en) begin
                    ctrl_d.state = ST_IDLE;
                end
            end
            default: ctrl_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '{state: ST_IDLE, irq: 1'b0, lvl: 2'd0, idx: '0, rst_cnt: 2'd0};
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign irq = ctrl_q.irq;
    assign ipl = ctrl_q.lvl;

    always_comb begin
        if (!rst_done) begin
            vab = ADDR_W'(RESET_VEC);
        end else if (ctrl_q.state == ST_SERVE) begin
            vab = ADDR_W'(VEC_BASE) + ADDR_W'(ctrl_q.idx) * ADDR_W'(VEC_STRIDE);
        end else begin
            vab = '0;
        end
    end

endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
    parameter int          ADDR_W    = 16,
    parameter logic [15:0] RESET_VEC = 16'h0080
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        sr_lvl,
    input logic              pic_en,
    input logic              iack,
    input logic              irq,
    input logic [1:0]        ipl,
    input logic [ADDR_W-1:0] vab
);

    logic [1:0] since_rst;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               since_rst <= 2'd0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    // R1
    a_r1_reset_vector_window: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst < 2'd2) |-> (vab == ADDR_W'(RESET_VEC)));

    // R4 and R5
    a_r5_level_not_below_mask: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> (ipl >= $past(sr_lvl)));

    // R6
    a_r6_rise_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(pic_en));

    // R7
    a_r7_drop_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(iack));

    // R8
    a_r8_vector_stable: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(irq && !pic_en, 2) && $past(irq && !pic_en) && irq) |-> $stable(vab));

endmodule

bind irq_prio_ctrl irqc_checker #(.ADDR_W(ADDR_W), .RESET_VEC(RESET_VEC)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .sr_lvl(sr_lvl),
    .pic_en(pic_en),
    .iack  (iack),
    .irq   (irq),
    .ipl   (ipl),
    .vab   (vab)
);

// File: tb/tb_irq_prio_ctrl.sv
module tb_irq_prio_ctrl;

    localparam int NP = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [7:0]    core_req = '0;
    logic [NP-1:0] prog_req = '0;
    logic [NP-1:0] prog_en = '0;
    logic [2*NP-1:0] prog_prio = '0;
    logic [1:0]    sr_lvl = 2'd0;
    logic          pic_en = 1'b1;
    logic          iack = 1'b0;
    logic          irq;
    logic [1:0]    ipl;
    logic [15:0]   vab;

    int checks = 0;
    int errors = 0;

    typedef struct { int idx; int lvl; } exp_t;
    exp_t sb[$];

    always #2 clk = ~clk;

    irq_prio_ctrl #(.NUM_PROG(NP)) dut (
        .clk(clk), .rst_n(rst_n), .core_req(core_req), .prog_req(prog_req),
        .prog_en(prog_en), .prog_prio(prog_prio), .sr_lvl(sr_lvl),
        .pic_en(pic_en), .iack(iack), .irq(irq), .ipl(ipl), .vab(vab)
    );

    function automatic int vec_of(int idx);
        return 16'h0100 + idx * 2;
    endfunction

    function automatic int lvl_of(int p);
        return (p == 0) ? 1 : (p == 1) ? 2 : 3;
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_all();
        core_req = '0;
        prog_req = '0;
        pic_en   = 1'b1;
        @(negedge clk);
        @(negedge clk);
    endtask

    // driver side: record the expected service
    task automatic expect_irq(int idx, int lvl);
        exp_t e;
        e.idx = idx;
        e.lvl = lvl;
        sb.push_back(e);
    endtask

    // monitor side: play the core, pop and compare
    task automatic core_take(string req);
        exp_t e;
        int waited = 0;
        while (!irq && waited < 8) begin
            @(negedge clk);
            waited++;
        end
        e = sb.pop_front();
        chk(irq == 1'b1, {req, " irq raised"}, irq, 1);
        chk(ipl == 2'(e.lvl), {req, " R5 level code"}, ipl, e.lvl);
        pic_en = 1'b0;
        @(negedge clk);
        chk(vab == 16'(vec_of(e.idx)), {req, " R6 vector"}, vab, vec_of(e.idx));
        iack = 1'b1;
        @(negedge clk);
        iack = 1'b0;
        chk(irq == 1'b0, "R7 irq low after iack", irq, 0);
        @(negedge clk);
        chk(irq == 1'b0, "R7 no reassert while pic_en low", irq, 0);
        clear_all();
    endtask

    task automatic expect_quiet(string req);
        repeat (4) @(negedge clk);
        chk(irq == 1'b0, req, irq, 0);
        clear_all();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // R1: reset state and release window
        repeat (3) @(negedge clk);
        chk(vab == 16'h0080, "R1 vector in reset", vab, 16'h0080);
        chk(irq == 1'b0, "R1 irq low in reset", irq, 0);
        chk(ipl == 2'd0, "R1 level zero in reset", ipl, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(vab == 16'h0080, "R1 vector after first edge", vab, 16'h0080);
        @(negedge clk);
        chk(vab == 16'h0000, "R1 vector gone after second edge", vab, 0);

        // R3: disabled programmable sources are ignored
        prog_req = '1;
        prog_prio = '1;
        expect_quiet("R3 disabled sources ignored");

        // R4: full mask table, programmable source 0 = index 8
        for (int s = 0; s < 4; s++) begin
            for (int p = 0; p < 4; p++) begin
                sr_lvl = 2'(s);
                prog_en = 8'h01;
                prog_prio[1:0] = 2'(p);
                prog_req = 8'h01;
                if (p >= s) begin
                    expect_irq(8, lvl_of(p));
                    core_take("R4 permitted");
                end else begin
                    expect_quiet("R4 masked");
                end
            end
        end

        // R2: core illegal-instruction exception at priority 3, no enable
        sr_lvl = 2'd3;
        prog_en = '0;
        core_req = 8'h01;
        expect_irq(0, 3);
        core_take("R2 core exception");
        core_req = 8'h20;   // software level 1 under mask 3
        expect_quiet("R2 software level 1 masked by 3");

        // R10: low-priority software interrupt
        sr_lvl = 2'd1;
        core_req = 8'h80;
        expect_quiet("R10 low priority masked by 1");
        sr_lvl = 2'd0;
        core_req = 8'h80;
        expect_irq(7, 0);
        core_take("R10 low priority accepted");

        // R9: priority beats index; ties go to lowest index
        prog_en = '1;
        prog_prio = '0;
        prog_prio[7:6] = 2'd1;
        core_req = 8'h40;   // software level 0 at index 6
        prog_req = 8'h08;   // source 3 (index 11) at priority 1
        expect_irq(11, 2);
        core_take("R9 higher priority wins");
        prog_prio[5:4]   = 2'd2;
        prog_prio[11:10] = 2'd2;
        prog_req = 8'h24;   // sources 2 and 5 at priority 2
        expect_irq(10, 3);
        core_take("R9 tie lowest index");
        core_req = 8'h10;   // software level 2, index 4
        prog_req = 8'h04;
        expect_irq(4, 3);
        core_take("R9 core wins tie");

        // R8: capture on pic_en fall, stable until iack
        prog_prio = '0;
        prog_prio[1:0] = 2'd1;
        prog_req = 8'h01;
        @(negedge clk);
        chk(irq == 1'b1, "R8 irq for priority 1", irq, 1);
        chk(ipl == 2'd2, "R8 level for priority 1", ipl, 2);
        core_req = 8'h01;
        pic_en = 1'b0;
        @(negedge clk);
        chk(vab == 16'(vec_of(0)), "R8 captured at enable fall", vab, vec_of(0));
        core_req = 8'h02;
        prog_req = '0;
        @(negedge clk);
        chk(vab == 16'(vec_of(0)), "R8 vector stable", vab, vec_of(0));
        @(negedge clk);
        chk(vab == 16'(vec_of(0)), "R8 vector still stable", vab, vec_of(0));
        iack = 1'b1;
        @(negedge clk);
        iack = 1'b0;
        chk(irq == 1'b0, "R7 drop after iack", irq, 0);
        chk(vab == 16'h0000, "R1 idle bus zero", vab, 0);
        @(negedge clk);
        chk(irq == 1'b0, "R7 pending but enable low", irq, 0);
        pic_en = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk(irq == 1'b1, "R7 reassert after enable returns", irq, 1);
        sb.delete();
        expect_irq(1, 3);
        core_take("R6 pending source served");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule